// File: doc/BRIEF.md
# Encoder Reply Readout Latch

This block stands between the serial receive path of an absolute position encoder and a host processor that has only a narrow parallel bus: eight data lines, a three-bit command code and a single control strobe. The receive path hands over each complete, checked reply as one wide word. The block stores that word in a holding latch. The host then reads it back one byte at a time.

The host raises the strobe to make a transfer. On the strobe's rising edge the block samples the command code. While the strobe is high the block drives the selected byte and asserts a drive-enable, which the pad ring uses to tristate the shared bus. One code asks the serial side for a new encoder read. Five codes select the five reply bytes. One code returns a status byte, and the last code clears the sticky error flags.

A reply that arrives while the host is partway through reading a frame is held back. The latch only takes it once that frame has been read to the end, so the host never sees bytes from two different replies in one frame.

Top module: `enc_readout_latch`

## Requirements
- R1: After reset, data_oe_o is 0, data_o is 0, read_req_o is 0, and a status read returns 8'h00.
- R2: Command code 0 produces a read_req_o pulse that lasts exactly one clock. The pulse rises in the same cycle as data_oe_o for that strobe.
- R3: Command codes 1 to 5 return reply bytes 0 to 4. Byte n is rx_data_i[8n+7:8n] of the reply held in the latch.
- R4: data_oe_o rises on the third clock edge after strb_i rises and falls on the third clock edge after strb_i falls. While data_oe_o is 0, data_o is 8'h00.
- R5: A reading frame opens with a code-1 read and closes with a code-5 read. While a frame is open, and also in the cycle where it closes, an arriving reply does not change the bytes the host reads. That reply enters the latch on the clock after the frame closes.
- R6: If more than one reply arrives during an open frame, only the newest one enters the latch after the frame closes.
- R7: Command code 6 returns the status byte. Bit 0 is busy (rx_busy_i or a pending read request), bit 1 is timeout, bit 2 is framing error, bit 3 is new-data, and bits 7 to 4 are 0.
- R8: The timeout and framing-error flags are set by pulses on rx_timeout_i and rx_ferr_i. They stay set until a code-7 command. If an error pulse arrives in the same cycle as the clear, the flag stays set.
- R9: The new-data flag sets whenever the latch updates and clears on a code-5 read. If a direct latch update and a code-5 read fall in the same cycle while no frame is open, the read returns the new reply's byte 4 and the flag stays set.
- R10: The command code is used only at the strobe's rising edge. Changing cmd_i while the strobe is high changes neither the driven byte nor read_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | One-cycle pulse: a complete, valid reply is on rx_data_i |
| rx_data_i | input | 40 | Decoded reply, byte 0 in the low bits |
| rx_busy_i | input | 1 | Serial path is busy with a transaction |
| rx_timeout_i | input | 1 | Pulse: the encoder did not answer in time |
| rx_ferr_i | input | 1 | Pulse: a framing error was detected |
| read_req_o | output | 1 | One-cycle request to start a new encoder read |
| cmd_i | input | 3 | Host command code |
| strb_i | input | 1 | Host transfer strobe |
| data_o | output | 8 | Data toward the host bus |
| data_oe_o | output | 1 | Bus drive-enable; the pad is high-impedance when low |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a code-5 read that closes a frame together with the arrival of a reply. The second pair is a code-7 clear together with a framing-error pulse. The bench raises rx_valid_i or rx_ferr_i in the exact cycle in which the synchronised strobe edge is decoded. For the frame-close case it does this both with a frame open and with no frame open. The results are judged at the ports: the byte returned by that read, the status byte read afterwards, and the bytes of the following frame.

// File: rtl/enc_rdo_pkg.sv
package enc_rdo_pkg;
  localparam int CMD_W = 3;
  localparam int BYTE_W = 8;

  typedef enum logic [CMD_W-1:0] {
    CMD_READ = 3'd0,
    CMD_B0   = 3'd1,
    CMD_B1   = 3'd2,
    CMD_B2   = 3'd3,
    CMD_B3   = 3'd4,
    CMD_B4   = 3'd5,
    CMD_STAT = 3'd6,
    CMD_CLR  = 3'd7
  } cmd_e;

  typedef struct packed {
    logic req;
    logic open_frm;
    logic close_frm;
    logic clr_err;
  } act_t;

  localparam int ST_BUSY = 0;
  localparam int ST_TMO  = 1;
  localparam int ST_FERR = 2;
  localparam int ST_NEW  = 3;
endpackage

// File: rtl/enc_rdo_strobe_sync.sv
module enc_rdo_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strb_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= strb_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/enc_rdo_cmd_decode.sv
module enc_rdo_cmd_decode
  import enc_rdo_pkg::*;
#(
  parameter int NBYTES = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             level_i,
  input  logic [CMD_W-1:0] cmd_i,
  output act_t             act_o,
  output logic [CMD_W-1:0] cmd_q_o,
  output logic             drive_o
);
  localparam logic [CMD_W-1:0] CloseCode = CMD_W'(NBYTES);

  always_comb begin
    act_o = '0;
    if (rise_i) begin
      act_o.req       = (cmd_i == CMD_READ);
      act_o.open_frm  = (cmd_i == CMD_B0);
      act_o.close_frm = (cmd_i == CloseCode);
      act_o.clr_err   = (cmd_i == CMD_CLR);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q_o <= '0;
      drive_o <= 1'b0;
    end else begin
      if (rise_i) cmd_q_o <= cmd_i;
      drive_o <= level_i;
    end
  end
endmodule

// File: rtl/enc_rdo_reply_latch.sv
module enc_rdo_reply_latch #(
  parameter int NBYTES = 5,
  localparam int W = NBYTES * 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rx_valid_i,
  input  logic [W-1:0] rx_data_i,
  input  logic         open_i,
  input  logic         close_i,
  output logic [W-1:0] latch_o,
  output logic         new_data_o,
  output logic         frame_open_o,
  output logic         upd_o
);
  logic [W-1:0] pend_q;
  logic         pend_v_q;
  logic         hold;

  // frozen for the whole frame, including the closing cycle
  assign hold  = frame_open_o;
  assign upd_o = ~hold & (rx_valid_i | pend_v_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o      <= '0;
      pend_q       <= '0;
      pend_v_q     <= 1'b0;
      frame_open_o <= 1'b0;
      new_data_o   <= 1'b0;
    end else begin
      if (upd_o) latch_o <= rx_valid_i ? rx_data_i : pend_q;

      if (rx_valid_i && hold) begin
        pend_q   <= rx_data_i;
        pend_v_q <= 1'b1;
      end else if (upd_o) begin
        pend_v_q <= 1'b0;
      end

      if (open_i)       frame_open_o <= 1'b1;
      else if (close_i) frame_open_o <= 1'b0;

      if (upd_o)        new_data_o <= 1'b1;
      else if (close_i) new_data_o <= 1'b0;
    end
  end
endmodule

// File: rtl/enc_rdo_bus_mux.sv
module enc_rdo_bus_mux
  import enc_rdo_pkg::*;
#(
  parameter int NBYTES = 5,
  localparam int W = NBYTES * 8
) (
  input  logic [CMD_W-1:0]  cmd_q_i,
  input  logic              drive_i,
  input  logic [W-1:0]      latch_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic [BYTE_W-1:0] data_o
);
  logic [BYTE_W-1:0] bytes [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_unpack
    assign bytes[g] = latch_i[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    data_o = '0;
    if (drive_i) begin
      if (cmd_q_i == CMD_STAT) data_o = status_i;
      for (int i = 0; i < NBYTES; i++) begin
        if (cmd_q_i == CMD_W'(i + 1)) data_o = bytes[i];
      end
    end
  end
endmodule

// File: rtl/enc_readout_latch.sv
module enc_readout_latch
  import enc_rdo_pkg::*;
#(
  parameter int NBYTES      = 5,
  parameter int SYNC_STAGES = 2,
  localparam int W = NBYTES * 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [W-1:0]     rx_data_i,
  input  logic             rx_busy_i,
  input  logic             rx_timeout_i,
  input  logic             rx_ferr_i,
  output logic             read_req_o,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             strb_i,
  output logic [7:0]       data_o,
  output logic             data_oe_o
);
  logic             strb_lvl, strb_rise;
  act_t             act;
  logic [CMD_W-1:0] cmd_q;
  logic [W-1:0]     latch_q;
  logic             new_data, frame_open, latch_upd;
  logic             tmo_q, ferr_q;
  logic [7:0]       status;

  enc_rdo_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .strb_i, .level_o(strb_lvl), .rise_o(strb_rise)
  );

  enc_rdo_cmd_decode #(.NBYTES(NBYTES)) u_dec (
    .clk_i, .rst_ni, .rise_i(strb_rise), .level_i(strb_lvl), .cmd_i,
    .act_o(act), .cmd_q_o(cmd_q), .drive_o(data_oe_o)
  );

  enc_rdo_reply_latch #(.NBYTES(NBYTES)) u_latch (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i,
    .open_i(act.open_frm), .close_i(act.close_frm),
    .latch_o(latch_q), .new_data_o(new_data), .frame_open_o(frame_open),
    .upd_o(latch_upd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q      <= 1'b0;
      ferr_q     <= 1'b0;
      read_req_o <= 1'b0;
    end else begin
      read_req_o <= act.req;
      // set wins over clear
      if (rx_timeout_i)     tmo_q <= 1'b1;
      else if (act.clr_err) tmo_q <= 1'b0;
      if (rx_ferr_i)        ferr_q <= 1'b1;
      else if (act.clr_err) ferr_q <= 1'b0;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_BUSY] = rx_busy_i | read_req_o;
    status[ST_TMO]  = tmo_q;
    status[ST_FERR] = ferr_q;
    status[ST_NEW]  = new_data;
  end

  enc_rdo_bus_mux #(.NBYTES(NBYTES)) u_mux (
    .cmd_q_i(cmd_q), .drive_i(data_oe_o), .latch_i(latch_q),
    .status_i(status), .data_o
  );
endmodule

// File: rtl/enc_rdo_chk.sv
module enc_rdo_chk #(
  parameter int W = 40
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         data_oe_o,
  input logic [7:0]   data_o,
  input logic         read_req_o,
  input logic         ferr_q,
  input logic         clr_err,
  input logic         frame_open,
  input logic [W-1:0] latch_q,
  input logic         new_data,
  input logic         latch_upd,
  input logic [2:0]   cmd_q
);
  p_idle_bus_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == 8'h00);

  p_req_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_req_o |=> !read_req_o);

  p_req_with_oe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_req_o |-> $rose(data_oe_o));

  p_status_pad_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && cmd_q == 3'd6) |-> data_o[7:4] == 4'h0);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ferr_q && !clr_err) |=> ferr_q);

  p_frozen_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_open |=> $stable(latch_q));

  p_newdata_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_upd |=> new_data);
endmodule

bind enc_readout_latch enc_rdo_chk #(.W(NBYTES * 8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .data_oe_o(data_oe_o), .data_o(data_o),
  .read_req_o(read_req_o), .ferr_q(ferr_q), .clr_err(act.clr_err),
  .frame_open(frame_open), .latch_q(latch_q), .new_data(new_data),
  .latch_upd(latch_upd), .cmd_q(cmd_q)
);

// File: tb/enc_readout_latch_bench.sv
module enc_readout_latch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [39:0] rx_data = '0;
  logic        rx_busy = 1'b0, rx_tmo = 1'b0, rx_ferr = 1'b0;
  logic        read_req;
  logic [2:0]  cmd = '0;
  logic        strb = 1'b0;
  logic [7:0]  data;
  logic        data_oe;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  enc_readout_latch u_enc_readout_latch (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_busy_i(rx_busy), .rx_timeout_i(rx_tmo), .rx_ferr_i(rx_ferr),
    .read_req_o(read_req), .cmd_i(cmd), .strb_i(strb),
    .data_o(data), .data_oe_o(data_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic inject(input logic [39:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  // one strobe cycle; optional reply or framing error pulse in the decode cycle
  task automatic access(input logic [2:0] c, input bit inj, input logic [39:0] d,
                        input bit ferr, output logic [7:0] dat, output logic req);
    @(negedge clk); strb = 1'b1; cmd = c;
    @(negedge clk);
    @(negedge clk); if (inj) begin rx_valid = 1'b1; rx_data = d; end
                    if (ferr) rx_ferr = 1'b1;
    @(negedge clk); rx_valid = 1'b0; rx_ferr = 1'b0;
    dat = data; req = read_req;
    if (data_oe !== 1'b1) chk("R4 oe during strobe", {7'd0, data_oe}, 8'h01);
    strb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (data_oe !== 1'b1) chk("R4 oe held two edges", {7'd0, data_oe}, 8'h01);
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] c, output logic [7:0] dat);
    logic r;
    access(c, 1'b0, '0, 1'b0, dat, r);
  endtask

  task automatic read_frame(input string req, input logic [39:0] exp);
    logic [7:0] v;
    for (int i = 0; i < 5; i++) begin
      rd(3'(i + 1), v);
      chk(req, v, exp[i*8 +: 8]);
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 oe", {7'd0, data_oe}, 8'h00);
    chk("R1 data", data, 8'h00);
    chk("R1 req", {7'd0, read_req}, 8'h00);
    rd(3'd6, v);
    chk("R1 status", v, 8'h00);
    chk("R4 released bus", data, 8'h00);
  endtask

  task automatic t_bytes;
    inject(40'h5A_C3_81_7E_24);
    read_frame("R3 bytes A", 40'h5A_C3_81_7E_24);
    inject(40'h01_FF_00_A5_96);
    read_frame("R3 bytes B", 40'h01_FF_00_A5_96);
  endtask

  task automatic t_request;
    logic [7:0] v;
    logic r;
    access(3'd0, 1'b0, '0, 1'b0, v, r);
    chk("R2 req pulse", {7'd0, r}, 8'h01);
    chk("R2 req done", {7'd0, read_req}, 8'h00);
    rx_busy = 1'b1;
    rd(3'd6, v);
    chk("R7 busy bit", v, 8'h01);
    rx_busy = 1'b0;
  endtask

  task automatic t_errors;
    logic [7:0] v;
    @(negedge clk); rx_tmo = 1'b1; rx_ferr = 1'b1;
    @(negedge clk); rx_tmo = 1'b0; rx_ferr = 1'b0;
    rd(3'd6, v);
    chk("R7 error bits", v, 8'h06);
    rd(3'd6, v);
    chk("R8 sticky", v, 8'h06);
    rd(3'd7, v);
    rd(3'd6, v);
    chk("R8 cleared", v, 8'h00);
  endtask

  task automatic t_clear_race;
    logic [7:0] v;
    logic r;
    access(3'd7, 1'b0, '0, 1'b1, v, r);
    rd(3'd6, v);
    chk("R8 set wins over clear", v, 8'h04);
    rd(3'd7, v);
    rd(3'd6, v);
    chk("R8 clear after race", v, 8'h00);
  endtask

  task automatic t_newdata;
    logic [7:0] v;
    inject(40'h11_22_33_44_55);
    rd(3'd6, v);
    chk("R9 new set", v, 8'h08);
    rd(3'd5, v);
    chk("R3 byte4", v, 8'h11);
    rd(3'd6, v);
    chk("R9 new cleared", v, 8'h00);
  endtask

  task automatic t_frame_lock;
    logic [7:0] v;
    inject(40'hA4_A3_A2_A1_A0);
    rd(3'd1, v);
    chk("R5 frame byte0", v, 8'hA0);
    inject(40'hB4_B3_B2_B1_B0);
    rd(3'd2, v);
    chk("R5 frozen byte1", v, 8'hA1);
    rd(3'd5, v);
    chk("R5 frozen byte4", v, 8'hA4);
    rd(3'd6, v);
    chk("R5 deferred new", v, 8'h08);
    read_frame("R5 deferred frame", 40'hB4_B3_B2_B1_B0);
  endtask

  task automatic t_pending_replace;
    logic [7:0] v;
    rd(3'd1, v);
    inject(40'hC0_C0_C0_C0_C0);
    inject(40'hD4_D3_D2_D1_D0);
    rd(3'd5, v);
    chk("R6 old frame byte4", v, 8'hB4);
    read_frame("R6 newest kept", 40'hD4_D3_D2_D1_D0);
  endtask

  task automatic t_newdata_race;
    logic [7:0] v;
    logic r;
    access(3'd5, 1'b1, 40'hE4_E3_E2_E1_E0, 1'b0, v, r);
    chk("R9 race returns new byte4", v, 8'hE4);
    rd(3'd6, v);
    chk("R9 set wins over clear", v, 8'h08);
    read_frame("R9 race frame", 40'hE4_E3_E2_E1_E0);
  endtask

  task automatic t_lock_race;
    logic [7:0] v;
    logic r;
    rd(3'd1, v);
    access(3'd5, 1'b1, 40'hF4_F3_F2_F1_F0, 1'b0, v, r);
    chk("R5 close-cycle reply deferred", v, 8'hE4);
    rd(3'd6, v);
    chk("R5 deferred after close", v, 8'h08);
    read_frame("R5 close race frame", 40'hF4_F3_F2_F1_F0);
  endtask

  task automatic t_cmd_change;
    @(negedge clk); strb = 1'b1; cmd = 3'd2;
    repeat (3) @(negedge clk);
    cmd = 3'd0;
    @(negedge clk);
    chk("R10 byte kept", data, 8'hF1);
    chk("R10 no req", {7'd0, read_req}, 8'h00);
    cmd = 3'd6;
    @(negedge clk);
    chk("R10 byte kept after change", data, 8'hF1);
    strb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R4 oe still high", {7'd0, data_oe}, 8'h01);
    @(negedge clk);
    chk("R4 oe low", {7'd0, data_oe}, 8'h00);
    chk("R4 idle data", data, 8'h00);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_request();
    t_errors();
    t_clear_race();
    t_newdata();
    t_frame_lock();
    t_pending_replace();
    t_newdata_race();
    t_lock_race();
    t_cmd_change();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule